// File: doc/BRIEF.md
# I2C Command-Driven Bus Master

This block is a single-master I2C controller run by a small register file. Software loads a clock prescaler, a target byte (7-bit slave address in bits 7:1 and a direction flag in bit 0), and, for transmits, a data byte. A single write to the command register then launches a bus operation. The four command flags pick which phases run: START, address byte, one data byte, STOP, and the acknowledge policy for received bytes.

The master drives SCL and SDA open-drain style. An output-enable high pulls the line low, and a released line floats high. SDA is sampled on an input pin. Each SCL bit slot is built from ten equal timer units: six with SCL low and four with SCL high. A unit lasts 2 × (prescaler + 1) system clocks. Without STOP, the bus stays held with SCL low, so a later command can continue the transfer or issue a repeated START. Completion, including an abort on a missing acknowledge, raises a one-cycle interrupt. A received byte is then available in the data register.

Top module: `i2c_cmd_master`

## Requirements
- R1: Register offsets are 0 prescaler, 1 target byte (bits 7:1 slave address, bit 0 = 1 for read), 2 data, and 3 command (write) / status (read). Command bits are 0 RUN, 1 START, 2 STOP and 3 ACK. Status bits are 0 BUSY, 1 ERROR, 2 ADDR_NACK and 3 DATA_NACK, and the upper bits read 0.
- R2: With prescaler P, SCL is low for 12 × (P + 1) clocks and one SCL period is 20 × (P + 1) clocks. P = 9 gives 200 clocks, which is 100 kHz from 20 MHz.
- R3: Command 0x7 with a write target runs START, the target byte, the data register byte and STOP. Each byte is sent MSB first, and the bus sees exactly 19 SCL falling edges.
- R4: BUSY reads 1 while an operation runs and 0 once it ends. Register writes are ignored while BUSY is set.
- R5: If the address byte is not acknowledged, status reads 0x06 and the data byte is skipped. A requested STOP is still issued (10 SCL falling edges in total).
- R6: If the data byte is not acknowledged, status reads 0x0A.
- R7: The interrupt is a single-cycle pulse, raised once when an operation completes or aborts, in the same cycle that BUSY drops.
- R8: With a read target, the received byte lands in the data register. The master drives ACK (SDA low) on the ninth bit when ACK = 1 and NACK (SDA released) when ACK = 0.
- R9: Without STOP, the bus stays held with SCL driven low after the operation. A following command with START produces a repeated START. A following command without START continues with a data byte.
- R10: SDA changes while SCL is high only to form START (falling) or STOP (rising). SDA holds each level at least one unit with SCL high.
- R11: After reset, status reads 0, both line enables are low, the interrupt is low, and neither line enable changes while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |
| irq_o | output | 1 | Operation-finished pulse |

## Verification
The assertions take for granted that the SCL line follows the master's own enable, because no slave stretches the clock. They also assume software issues commands only while BUSY is clear, so the flags of a running operation never change underneath the sequencer. The bench keeps to this: its slave model drives SDA only while SCL is low and never touches SCL. Each command is launched only after the previous interrupt, and the deliberate writes made during BUSY are register writes that the design is required to drop.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int unsigned LOW_UNITS  = 6;
  localparam int unsigned HIGH_UNITS = 4;
  localparam int unsigned BIT_UNITS  = LOW_UNITS + HIGH_UNITS;
  localparam int unsigned MOVE_UNIT  = 1;                             // SDA data edge, SCL low
  localparam int unsigned COND_UNIT  = LOW_UNITS + HIGH_UNITS / 2;    // start/stop edge, SCL high
  localparam int unsigned UNIT_W     = $clog2(BIT_UNITS);
  localparam int unsigned REG_W      = 8;

  localparam logic [1:0] REG_PRESC = 2'd0;
  localparam logic [1:0] REG_TGT   = 2'd1;
  localparam logic [1:0] REG_DATA  = 2'd2;
  localparam logic [1:0] REG_CMD   = 2'd3;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WBIT, OP_RBIT} bit_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_TX, ST_ACKIN, ST_RX, ST_ACKOUT, ST_STOP
  } seq_state_e;

  typedef struct packed {
    logic ack;
    logic stop;
    logic start;
    logic run;
  } cmd_t;
endpackage

// File: rtl/i2c_unit_timer.sv
module i2c_unit_timer #(
  parameter int unsigned PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  localparam int unsigned CNT_W = PRESC_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // unit = 2*(P+1) clocks -> terminal count 2P+1
  assign lim    = {presc_i, 1'b1};
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i || !en_i || tick_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  bit_op_e            op_i,
  input  logic               wbit_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               sda_i,
  output logic               fin_o,
  output logic               rx_o,
  output logic               scl_oe_o,
  output logic               sda_oe_o,
  output logic               cond_o
);
  logic              active_q, idle_bus_q, sda_q, rx_q, wbit_q, tick;
  bit_op_e           op_q;
  logic [UNIT_W-1:0] unit_q;

  i2c_unit_timer #(.PRESC_W(PRESC_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (active_q),
    .clr_i  (go_i),
    .presc_i(presc_i),
    .tick_o (tick)
  );

  assign fin_o = active_q && tick && (unit_q == UNIT_W'(BIT_UNITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           idle_bus_q <= 1'b1;
    else if (fin_o && op_q == OP_START)    idle_bus_q <= 1'b0;
    else if (fin_o && op_q == OP_STOP)     idle_bus_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      op_q     <= OP_STOP;
      unit_q   <= '0;
      wbit_q   <= 1'b0;
      sda_q    <= 1'b0;
      rx_q     <= 1'b0;
    end else if (go_i) begin
      active_q <= 1'b1;
      op_q     <= op_i;
      wbit_q   <= wbit_i;
      // from an idle bus the start skips the low half
      unit_q   <= (op_i == OP_START && idle_bus_q) ? UNIT_W'(LOW_UNITS) : '0;
    end else if (fin_o) begin
      active_q <= 1'b0;
    end else if (active_q && tick) begin
      unit_q <= unit_q + 1'b1;
      if (unit_q == UNIT_W'(MOVE_UNIT - 1)) begin
        case (op_q)
          OP_STOP: sda_q <= 1'b1;
          OP_WBIT: sda_q <= ~wbit_q;
          default: sda_q <= 1'b0;
        endcase
      end
      if (unit_q == UNIT_W'(COND_UNIT - 1)) begin
        case (op_q)
          OP_START: sda_q <= 1'b1;
          OP_STOP:  sda_q <= 1'b0;
          OP_RBIT:  rx_q  <= sda_i;
          default:  ;
        endcase
      end
    end
  end

  assign scl_oe_o = active_q ? (unit_q < UNIT_W'(LOW_UNITS)) : ~idle_bus_q;
  assign sda_oe_o = sda_q;
  assign rx_o     = rx_q;
  assign cond_o   = active_q && (op_q == OP_START || op_q == OP_STOP);
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned PRESC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             sda_i,
  output logic             irq_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [REG_W-1:0]   tgt_q, data_q, data_d, sh_q, sh_d;
  logic [2:0]         cnt_q, cnt_d;
  logic               addr_ph_q, addr_ph_d, an_q, an_d, dn_q, dn_d, irq_q;
  cmd_t               cmd_q, cmd_d;
  seq_state_e         state_q, state_d;

  logic    go, wbit, fin, rx, done, launch, wrap, busy, bit_cond;
  bit_op_e op;

  assign busy = (state_q != ST_IDLE);

  i2c_bit_ctrl #(.PRESC_W(PRESC_W)) u_bit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .op_i    (op),
    .wbit_i  (wbit),
    .presc_i (presc_q),
    .sda_i   (sda_i),
    .fin_o   (fin),
    .rx_o    (rx),
    .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o),
    .cond_o  (bit_cond)
  );

  always_comb begin
    go = 1'b0;  op = OP_WBIT;  wbit = 1'b0;  done = 1'b0;
    launch = 1'b0;  wrap = 1'b0;
    state_d = state_q;  sh_d = sh_q;  cnt_d = cnt_q;  addr_ph_d = addr_ph_q;
    data_d = data_q;  an_d = an_q;  dn_d = dn_q;  cmd_d = cmd_q;
    if (state_q == ST_IDLE) begin
      if (reg_we_i && reg_addr_i == REG_DATA) data_d = reg_wdata_i;
      if (reg_we_i && reg_addr_i == REG_CMD) begin
        cmd_d = cmd_t'(reg_wdata_i[3:0]);
        an_d  = 1'b0;
        dn_d  = 1'b0;
        if (cmd_d.start) begin
          go = 1'b1;  op = OP_START;  state_d = ST_START;
        end else if (cmd_d.run) begin
          launch = 1'b1;
        end else if (cmd_d.stop) begin
          go = 1'b1;  op = OP_STOP;  state_d = ST_STOP;
        end
      end
    end else if (fin) begin
      unique case (state_q)
        ST_START: begin
          sh_d = tgt_q;  cnt_d = '0;  addr_ph_d = 1'b1;
          go = 1'b1;  op = OP_WBIT;  wbit = tgt_q[REG_W-1];  state_d = ST_TX;
        end
        ST_TX: begin
          if (cnt_q == 3'd7) begin
            go = 1'b1;  op = OP_RBIT;  state_d = ST_ACKIN;
          end else begin
            cnt_d = cnt_q + 1'b1;  sh_d = {sh_q[REG_W-2:0], 1'b0};
            go = 1'b1;  op = OP_WBIT;  wbit = sh_q[REG_W-2];
          end
        end
        ST_ACKIN: begin
          if (rx) begin
            if (addr_ph_q) an_d = 1'b1;
            else           dn_d = 1'b1;
            wrap = 1'b1;
          end else if (addr_ph_q && cmd_q.run) begin
            launch = 1'b1;
          end else begin
            wrap = 1'b1;
          end
        end
        ST_RX: begin
          sh_d = {sh_q[REG_W-2:0], rx};
          if (cnt_q == 3'd7) begin
            data_d = sh_d;
            go = 1'b1;  op = OP_WBIT;  wbit = ~cmd_q.ack;  state_d = ST_ACKOUT;
          end else begin
            cnt_d = cnt_q + 1'b1;
            go = 1'b1;  op = OP_RBIT;
          end
        end
        ST_ACKOUT: wrap = 1'b1;
        ST_STOP: begin
          done = 1'b1;  state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end

    if (launch) begin
      addr_ph_d = 1'b0;  cnt_d = '0;  go = 1'b1;
      if (tgt_q[0]) begin
        op = OP_RBIT;  state_d = ST_RX;
      end else begin
        sh_d = data_q;  op = OP_WBIT;  wbit = data_q[REG_W-1];  state_d = ST_TX;
      end
    end
    if (wrap) begin
      if (cmd_d.stop) begin
        go = 1'b1;  op = OP_STOP;  state_d = ST_STOP;
      end else begin
        done = 1'b1;  state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q   <= '0;
      tgt_q     <= '0;
      data_q    <= '0;
      sh_q      <= '0;
      cnt_q     <= '0;
      addr_ph_q <= 1'b0;
      an_q      <= 1'b0;
      dn_q      <= 1'b0;
      cmd_q     <= '0;
      state_q   <= ST_IDLE;
      irq_q     <= 1'b0;
    end else begin
      if (!busy && reg_we_i && reg_addr_i == REG_PRESC) presc_q <= reg_wdata_i[PRESC_W-1:0];
      if (!busy && reg_we_i && reg_addr_i == REG_TGT)   tgt_q   <= reg_wdata_i;
      data_q    <= data_d;
      sh_q      <= sh_d;
      cnt_q     <= cnt_d;
      addr_ph_q <= addr_ph_d;
      an_q      <= an_d;
      dn_q      <= dn_d;
      cmd_q     <= cmd_d;
      state_q   <= state_d;
      irq_q     <= done;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_PRESC: reg_rdata_o = REG_W'(presc_q);
      REG_TGT:   reg_rdata_o = tgt_q;
      REG_DATA:  reg_rdata_o = data_q;
      default:   reg_rdata_o = {4'b0, dn_q, an_q, an_q | dn_q, busy};
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_oe_i,
  input logic sda_oe_i,
  input logic cond_i,
  input logic busy_i,
  input logic irq_i,
  input logic addr_nack_i,
  input logic data_nack_i
);
  // R10
  sda_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) && !scl_oe_i && !$past(scl_oe_i) |-> cond_i);

  // R7
  irq_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> irq_i);

  // R7
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  // R5
  nack_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({addr_nack_i, data_nack_i}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !$past(busy_i) |-> $stable(scl_oe_i) && $stable(sda_oe_i));
endmodule

bind i2c_cmd_master i2c_cmd_master_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_oe_i   (scl_oe_o),
  .sda_oe_i   (sda_oe_o),
  .cond_i     (bit_cond),
  .busy_i     (busy),
  .irq_i      (irq_o),
  .addr_nack_i(an_q),
  .data_nack_i(dn_q)
);

// File: tb/test_i2c_cmd_master.sv
module test_i2c_cmd_master;
  localparam logic [6:0] SLV = 7'h3B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       scl_oe, sda_oe, irq;
  logic       sl_drv = 1'b0;
  logic       scl_line, sda_line;

  always #10 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | sl_drv);

  i2c_cmd_master i_i2c_cmd_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .scl_oe_o(scl_oe),
    .sda_oe_o(sda_oe), .sda_i(sda_line), .irq_o(irq)
  );

  int errs = 0, checks = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // slave model
  int         sl_cnt = 0, sl_idx = 0, n_starts = 0, n_stops = 0;
  logic       sl_addr_ph = 1'b1, sl_sel = 1'b0, sl_rd = 1'b0, ack_data_en = 1'b1;
  logic       last_mack = 1'b0;
  logic [7:0] sl_sh = 0, sl_tx = 0, rd_a = 0, rd_b = 0, got_addr = 0, got_data = 0;

  always @(negedge sda_line) if (scl_line) begin
    n_starts++; sl_cnt = 0; sl_addr_ph = 1'b1; sl_idx = 0; sl_drv = 1'b0;
  end
  always @(posedge sda_line) if (scl_line) begin
    n_stops++; sl_sel = 1'b0;
  end
  always @(posedge scl_line) begin
    if (sl_cnt < 8) sl_sh = {sl_sh[6:0], sda_line};
    else if (sl_sel && sl_rd && !sl_addr_ph) begin
      last_mack = sda_line;
      if (sda_line) sl_sel = 1'b0;
    end
    sl_cnt++;
  end
  always @(negedge scl_line) begin
    if (sl_cnt == 8) begin
      if (sl_addr_ph) begin
        got_addr = sl_sh; sl_sel = (sl_sh[7:1] == SLV); sl_rd = sl_sh[0]; sl_drv = sl_sel;
      end else if (!sl_rd) begin
        if (sl_sel) got_data = sl_sh;
        sl_drv = sl_sel && ack_data_en;
      end else sl_drv = 1'b0;
    end else if (sl_cnt == 9) begin
      sl_cnt = 0; sl_addr_ph = 1'b0;
      if (sl_sel && sl_rd) begin
        sl_tx = (sl_idx == 0) ? rd_a : rd_b; sl_idx++; sl_drv = ~sl_tx[7];
      end else sl_drv = 1'b0;
    end else if (sl_cnt >= 1 && sl_cnt <= 7 && sl_sel && sl_rd && !sl_addr_ph) begin
      sl_drv = ~sl_tx[7-sl_cnt];
    end
  end

  // line timing monitor
  int   cyc = 0, t_fall = 0, period = 0, low_len = 0, n_falls = 0, n_irq = 0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (irq) n_irq++;
    if (scl_oe && !prev_oe) begin period = cyc - t_fall; t_fall = cyc; n_falls++; end
    if (!scl_oe && prev_oe) low_len = cyc - t_fall;
    prev_oe = scl_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 50000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(2'd3, c); wait_irq();
  endtask

  logic [7:0] v;
  int s0, p0, f0, i0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd3, v); chk("R11 status", v, 0);
    chk("R11 scl_oe", scl_oe, 0); chk("R11 sda_oe", sda_oe, 0); chk("R11 irq", irq, 0);
    repeat (20) @(negedge clk);
    chk("R11 idle quiet", n_falls, 0);

    // R2 nominal 100 kHz setting, R3 single write, R1 register readback
    wr(2'd0, 8'd9); wr(2'd1, 8'h76); wr(2'd2, 8'hA5);
    rd(2'd0, v); chk("R1 presc readback", v, 9);
    rd(2'd1, v); chk("R1 target readback", v, 8'h76);
    f0 = n_falls; i0 = n_irq; s0 = n_starts; p0 = n_stops;
    cmd(8'h07);
    chk("R2 period P=9", period, 200); chk("R2 low P=9", low_len, 120);
    chk("R3 addr byte", got_addr, 8'h76); chk("R3 data byte", got_data, 8'hA5);
    chk("R3 scl falls", n_falls - f0, 19);
    chk("R10 starts", n_starts - s0, 1); chk("R10 stops", n_stops - p0, 1);
    chk("R7 one irq", n_irq - i0, 1);
    rd(2'd3, v); chk("R4 status done", v, 0);

    // R2/R3 sweep of prescaler and data patterns
    for (int p = 0; p < 4; p++) begin
      wr(2'd0, 8'(p));
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'(p * 37 + 3);
        wr(2'd2, d); cmd(8'h07);
        chk("R3 sweep data", got_data, d);
        chk("R2 sweep period", period, 20 * (p + 1));
        chk("R2 sweep low", low_len, 12 * (p + 1));
      end
    end

    // R4 busy flag and ignored writes
    wr(2'd0, 8'd1); wr(2'd2, 8'h3C);
    wr(2'd3, 8'h07);
    repeat (5) @(negedge clk);
    rd(2'd3, v); chk("R4 busy set", v[0], 1);
    wr(2'd2, 8'hFF); wr(2'd1, 8'h00);
    wait_irq();
    rd(2'd2, v); chk("R4 data write ignored", v, 8'h3C);
    rd(2'd1, v); chk("R4 target write ignored", v, 8'h76);
    chk("R4 sent byte", got_data, 8'h3C);
    rd(2'd3, v); chk("R4 busy clear", v[0], 0);

    // R5 address NACK with STOP
    wr(2'd1, 8'h20); f0 = n_falls; p0 = n_stops; i0 = n_irq;
    cmd(8'h07);
    rd(2'd3, v); chk("R5 status", v, 8'h06);
    chk("R5 data skipped", n_falls - f0, 10); chk("R5 stop issued", n_stops - p0, 1);
    chk("R7 irq on abort", n_irq - i0, 1);

    // R5 address NACK held, then stop-only command
    p0 = n_stops; cmd(8'h03);
    rd(2'd3, v); chk("R5 status hold", v, 8'h06);
    chk("R9 no stop", n_stops - p0, 0); chk("R9 scl held", scl_oe, 1);
    f0 = n_falls; cmd(8'h04);
    chk("R9 stop only", n_stops - p0, 1); chk("R9 scl released", scl_oe, 0);
    rd(2'd3, v); chk("R1 status cleared", v, 0);

    // R6 data NACK
    wr(2'd1, 8'h76); ack_data_en = 1'b0; p0 = n_stops;
    cmd(8'h07);
    rd(2'd3, v); chk("R6 status", v, 8'h0A); chk("R6 stop", n_stops - p0, 1);
    ack_data_en = 1'b1;

    // R8 single byte reads with NACK
    wr(2'd1, 8'h77);
    for (int k = 0; k < 4; k++) begin
      rd_a = (k == 0) ? 8'hC3 : (k == 1) ? 8'h00 : (k == 2) ? 8'hFF : 8'h96;
      cmd(8'h07);
      rd(2'd2, v); chk("R8 read byte", v, rd_a);
      chk("R8 master nack", last_mack, 1);
      rd(2'd3, v); chk("R8 status", v, 0);
    end

    // R8/R9 read with ACK and held bus, then continued read
    rd_a = 8'h5E; rd_b = 8'hA1; p0 = n_stops; s0 = n_starts;
    cmd(8'h0B);
    rd(2'd2, v); chk("R8 first byte", v, 8'h5E);
    chk("R8 master ack", last_mack, 0);
    chk("R9 held no stop", n_stops - p0, 0); chk("R9 held scl", scl_oe, 1);
    cmd(8'h05);
    rd(2'd2, v); chk("R9 continued byte", v, 8'hA1);
    chk("R8 final nack", last_mack, 1);
    chk("R9 no new start", n_starts - s0, 1); chk("R9 stop", n_stops - p0, 1);

    // R9 repeated start
    wr(2'd1, 8'h76); wr(2'd2, 8'h42); s0 = n_starts; p0 = n_stops;
    cmd(8'h03);
    chk("R9 first write", got_data, 8'h42); chk("R9 no stop yet", n_stops - p0, 0);
    wr(2'd2, 8'h24); f0 = n_falls;
    cmd(8'h07);
    chk("R9 repeated start", n_starts - s0, 2); chk("R9 final stop", n_stops - p0, 1);
    chk("R9 second write", got_data, 8'h24); chk("R10 falls after rs", n_falls - f0, 19);
    chk("R11 lines idle", scl_oe | sda_oe, 0);

    summary();
  end
endmodule